// File: doc/BRIEF.md
# Cascadable Dot-Matrix LCD Column Driver Core

This block is the digital core of a column (segment) driver for a dot-matrix LCD panel. Pixel data arrives as 4-bit nibbles. The core samples each nibble on the falling edge of a shift clock and writes it into an 80-column line register. The core runs on a fast system clock. It detects the falling edges of the shift clock and of the latch strobe by sampling those inputs.

A direction input sets two things: whether the nibbles fill the line from the low column end or from the high column end, and which of the two cascade pins acts as enable input and which as enable output. A chip takes nibbles only while its enable input is low. Once it has taken a full line of 20 nibbles, it stops taking data and pulls its enable output low, which hands the data stream to the next chip in the chain. A falling edge on the latch strobe copies the line into an output latch and re-arms the chip for the next line.

Each column turns its latched bit, the frame alternation input and an active-low blanking input into a 2-bit drive-level code. The analog switches outside this block decode that code.

Top module: `lcdseg_drv`

## Requirements
- R1: A synchronous active-low reset clears the line register, the output latch, the nibble counter and the full flag. Afterwards both cascade outputs are high, and each column shows the level its cleared bit gives under the current alternation and blanking inputs.
- R2: With `dir_rl`=0, a falling edge on `shift_clk` that the chip accepts writes `din[b]` of the k-th accepted nibble (k counted from 0) into column 4k+b.
- R3: With `dir_rl`=1, the k-th accepted nibble writes `din[b]` into column 79-(4k+b).
- R4: With `dir_rl`=0, `en_r_i` is the enable input and `en_l_o` the enable output. With `dir_rl`=1, `en_l_i` is the enable input and `en_r_o` the enable output. The enable input that is not selected has no effect, and the output that is not selected stays high.
- R5: While the selected enable input is high, shift-clock edges change nothing.
- R6: After 20 accepted nibbles the full flag sets. Further nibbles are then ignored, and the selected enable output goes low until the next latch edge.
- R7: A falling edge on `latch_stb` copies the line into the output latch and clears the full flag and the nibble counter. Without that edge, shifted data never reaches `lvl`. If a shift edge and a latch edge fall in the same cycle, the latch wins and the nibble is dropped.
- R8: With `blank_n`=1, column c drives `lvl[2c+1:2c]` from its latched bit Q and `ac_m`: ac_m=0,Q=1 gives 00; ac_m=0,Q=0 gives 01; ac_m=1,Q=0 gives 10; ac_m=1,Q=1 gives 11.
- R9: With `blank_n`=0, every column drives 00, whatever `ac_m` and the latched bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_clk | input | 1 | Nibble shift clock; its falling edge samples `din` |
| latch_stb | input | 1 | Line latch strobe; acts on its falling edge |
| dir_rl | input | 1 | Fill direction and cascade pin role select |
| din | input | 4 | Pixel nibble |
| ac_m | input | 1 | Frame alternation signal |
| blank_n | input | 1 | Active-low display blanking |
| en_r_i | input | 1 | Right cascade pin, enable input when `dir_rl`=0 |
| en_l_i | input | 1 | Left cascade pin, enable input when `dir_rl`=1 |
| en_r_o | output | 1 | Right cascade pin, enable output when `dir_rl`=1 |
| en_l_o | output | 1 | Left cascade pin, enable output when `dir_rl`=0 |
| lvl | output | 160 | 2-bit drive-level code per column |

## Verification
A wrong nibble count is visible at the enable output: that output falls one nibble early or late, or never falls, and this shows within a cycle of the 20th accepted edge. A bad column mapping or a write that should have been blocked stays hidden in the line register. It reaches `lvl` only at the next latch edge, so the bench latches after every stimulus phase and compares all 80 columns. A stale full flag shows up as a line that refuses data after the latch.

// File: rtl/lcdseg_pkg.sv
package lcdseg_pkg;
   typedef enum logic [1:0] {
      LV_SEL_HI  = 2'b00,
      LV_NSEL_HI = 2'b01,
      LV_NSEL_LO = 2'b10,
      LV_SEL_LO  = 2'b11
   } lvl_e;

   function automatic lvl_e lvl_code(input logic m, input logic q, input logic blank_n);
      lvl_e r;
      if (!blank_n)      r = LV_SEL_HI;
      else if (!m && q)  r = LV_SEL_HI;
      else if (!m)       r = LV_NSEL_HI;
      else if (!q)       r = LV_NSEL_LO;
      else               r = LV_SEL_LO;
      return r;
   endfunction
endpackage

// File: rtl/lcdseg_fall.sv
module lcdseg_fall #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sig,
   output logic [W-1:0] fall
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sig;
   end

   assign fall = prev_q & ~sig;
endmodule

// File: rtl/lcdseg_fill.sv
module lcdseg_fill #(
   parameter int COLS = 80,
   parameter int GRP  = 4,
   localparam int NGRP = COLS / GRP,
   localparam int CW   = $clog2(NGRP + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            shift_ev,
   input  logic            latch_ev,
   input  logic            dir_rl,
   input  logic [GRP-1:0]  din,
   input  logic            en_r_i,
   input  logic            en_l_i,
   output logic            en_r_o,
   output logic            en_l_o,
   output logic            en_in,
   output logic [COLS-1:0] line_q,
   output logic            full_q,
   output logic [CW-1:0]   grp_cnt
);
   logic            take;
   logic [COLS-1:0] line_d;

   assign en_in = dir_rl ? en_l_i : en_r_i;
   assign take  = shift_ev & ~en_in & ~full_q & ~latch_ev;

   for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int LG = c / GRP;
      localparam int LB = c % GRP;
      localparam int RG = (COLS - 1 - c) / GRP;
      localparam int RB = (COLS - 1 - c) % GRP;
      logic hit;
      assign hit = dir_rl ? (grp_cnt == CW'(RG)) : (grp_cnt == CW'(LG));
      assign line_d[c] = (take && hit) ? (dir_rl ? din[RB] : din[LB]) : line_q[c];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q  <= '0;
         grp_cnt <= '0;
         full_q  <= 1'b0;
      end else begin
         line_q <= line_d;
         if (latch_ev) begin
            grp_cnt <= '0;
            full_q  <= 1'b0;
         end else if (take) begin
            grp_cnt <= grp_cnt + 1'b1;
            if (grp_cnt == CW'(NGRP - 1)) full_q <= 1'b1;
         end
      end
   end

   assign en_l_o = dir_rl ? 1'b1 : ~full_q;
   assign en_r_o = dir_rl ? ~full_q : 1'b1;
endmodule

// File: rtl/lcdseg_outstage.sv
module lcdseg_outstage
   import lcdseg_pkg::*;
#(
   parameter int COLS = 80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              latch_ev,
   input  logic [COLS-1:0]   line_q,
   input  logic              ac_m,
   input  logic              blank_n,
   output logic [COLS-1:0]   latch_q,
   output logic [2*COLS-1:0] lvl
);
   always_ff @(posedge clk) begin
      if (!rst_n)        latch_q <= '0;
      else if (latch_ev) latch_q <= line_q;
   end

   for (genvar c = 0; c < COLS; c++) begin : g_lvl
      assign lvl[2*c +: 2] = lvl_code(ac_m, latch_q[c], blank_n);
   end
endmodule

// File: rtl/lcdseg_drv.sv
module lcdseg_drv #(
   parameter int COLS = 80,
   parameter int GRP  = 4,
   localparam int NGRP = COLS / GRP,
   localparam int CW   = $clog2(NGRP + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_clk,
   input  logic              latch_stb,
   input  logic              dir_rl,
   input  logic [GRP-1:0]    din,
   input  logic              ac_m,
   input  logic              blank_n,
   input  logic              en_r_i,
   input  logic              en_l_i,
   output logic              en_r_o,
   output logic              en_l_o,
   output logic [2*COLS-1:0] lvl
);
   if (GRP < 1 || COLS < GRP) begin : g_bad_size
      $error("lcdseg_drv: GRP must be at least 1 and no larger than COLS");
   end
   if (COLS % GRP != 0) begin : g_bad_div
      $error("lcdseg_drv: COLS must be a multiple of GRP");
   end

   logic [1:0]      fall;
   logic            shift_ev, latch_ev, en_in, full_q;
   logic [COLS-1:0] line_q, latch_q;
   logic [CW-1:0]   grp_cnt;

   lcdseg_fall #(.W(2)) u_fall (
      .clk(clk), .rst_n(rst_n), .sig({latch_stb, shift_clk}), .fall(fall)
   );
   assign shift_ev = fall[0];
   assign latch_ev = fall[1];

   lcdseg_fill #(.COLS(COLS), .GRP(GRP)) u_fill (
      .clk(clk), .rst_n(rst_n), .shift_ev(shift_ev), .latch_ev(latch_ev),
      .dir_rl(dir_rl), .din(din), .en_r_i(en_r_i), .en_l_i(en_l_i),
      .en_r_o(en_r_o), .en_l_o(en_l_o), .en_in(en_in), .line_q(line_q),
      .full_q(full_q), .grp_cnt(grp_cnt)
   );

   lcdseg_outstage #(.COLS(COLS)) u_out (
      .clk(clk), .rst_n(rst_n), .latch_ev(latch_ev), .line_q(line_q),
      .ac_m(ac_m), .blank_n(blank_n), .latch_q(latch_q), .lvl(lvl)
   );
endmodule

// File: rtl/lcdseg_drv_chk.sv
module lcdseg_drv_chk #(
   parameter int COLS = 80,
   parameter int GRP  = 4,
   localparam int NGRP = COLS / GRP,
   localparam int CW   = $clog2(NGRP + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dir_rl,
   input logic              blank_n,
   input logic              en_r_o,
   input logic              en_l_o,
   input logic              en_in,
   input logic              shift_ev,
   input logic              latch_ev,
   input logic              full_q,
   input logic [CW-1:0]     grp_cnt,
   input logic [COLS-1:0]   line_q,
   input logic [COLS-1:0]   latch_q,
   input logic [2*COLS-1:0] lvl
);
   // R9
   blank_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !blank_n |-> lvl == '0);
   // R4
   idle_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dir_rl |-> en_l_o);
   // R4
   idle_pin_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_rl |-> en_r_o);
   // R5
   no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_ev && en_in) |=> $stable(line_q));
   // R6
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grp_cnt <= CW'(NGRP));
   // R6
   full_stick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && !latch_ev) |=> full_q);
   // R6
   handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full_q |-> !(en_r_o && en_l_o));
   // R7
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_ev |=> $stable(latch_q));
   // R7
   rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latch_ev |=> (!full_q && grp_cnt == '0));
endmodule

bind lcdseg_drv lcdseg_drv_chk #(.COLS(COLS), .GRP(GRP)) u_chk (
   .clk(clk), .rst_n(rst_n), .dir_rl(dir_rl), .blank_n(blank_n),
   .en_r_o(en_r_o), .en_l_o(en_l_o), .en_in(en_in), .shift_ev(shift_ev),
   .latch_ev(latch_ev), .full_q(full_q), .grp_cnt(grp_cnt),
   .line_q(line_q), .latch_q(latch_q), .lvl(lvl)
);

// File: tb/lcdseg_drv_bench.sv
module lcdseg_drv_bench;
   localparam int COLS = 80;
   localparam int GRP  = 4;
   localparam int NGRP = COLS / GRP;
   localparam int VW   = 2 * COLS + 2;

   typedef struct {
      string         tag;
      logic [VW-1:0] v;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0, shift_clk = 1'b0, latch_stb = 1'b0, dir_rl = 1'b0;
   logic [GRP-1:0] din = '0;
   logic ac_m = 1'b0, blank_n = 1'b1, en_r_i = 1'b0, en_l_i = 1'b0;
   logic en_r_o, en_l_o;
   logic [2*COLS-1:0] lvl;

   int total = 0, bad = 0;
   bit done = 0;
   item_t q[$];

   logic [COLS-1:0] m_line = '0, m_lat = '0;
   int m_cnt = 0;

   always #10 clk = ~clk;

   lcdseg_drv u_lcdseg_drv (
      .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .latch_stb(latch_stb),
      .dir_rl(dir_rl), .din(din), .ac_m(ac_m), .blank_n(blank_n),
      .en_r_i(en_r_i), .en_l_i(en_l_i), .en_r_o(en_r_o), .en_l_o(en_l_o),
      .lvl(lvl)
   );

   function automatic logic [VW-1:0] exp_vec();
      logic [VW-1:0] v;
      logic full;
      full = (m_cnt == NGRP);
      for (int c = 0; c < COLS; c++) begin
         if (!blank_n)      v[2*c +: 2] = 2'b00;
         else if (!ac_m)    v[2*c +: 2] = m_lat[c] ? 2'b00 : 2'b01;
         else               v[2*c +: 2] = m_lat[c] ? 2'b11 : 2'b10;
      end
      v[VW-1] = dir_rl ? ~full : 1'b1;
      v[VW-2] = dir_rl ? 1'b1 : ~full;
      return v;
   endfunction

   task automatic expect_now(input string tag);
      item_t it;
      it.tag = tag;
      it.v   = exp_vec();
      q.push_back(it);
      wait (q.size() == 0);
   endtask

   task automatic shift(input logic [GRP-1:0] d);
      logic en_sel;
      @(negedge clk);
      din = d;
      shift_clk = 1'b1;
      repeat (2) @(negedge clk);
      shift_clk = 1'b0;
      repeat (2) @(negedge clk);
      en_sel = dir_rl ? en_l_i : en_r_i;
      if (!en_sel && m_cnt < NGRP) begin
         for (int b = 0; b < GRP; b++) begin
            if (dir_rl) m_line[COLS-1-(GRP*m_cnt+b)] = d[b];
            else        m_line[GRP*m_cnt+b] = d[b];
         end
         m_cnt++;
      end
   endtask

   task automatic latch();
      @(negedge clk);
      latch_stb = 1'b1;
      repeat (2) @(negedge clk);
      latch_stb = 1'b0;
      repeat (2) @(negedge clk);
      m_lat = m_line;
      m_cnt = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_line = '0;
      m_lat  = '0;
      m_cnt  = 0;
   endtask

   initial begin : monitor
      item_t it;
      logic [VW-1:0] got;
      forever begin
         wait (q.size() > 0);
         @(negedge clk);
         it  = q.pop_front();
         got = {en_r_o, en_l_o, lvl};
         total++;
         if (got !== it.v) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", it.tag, got, it.v);
         end
      end
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : driver
      do_reset();
      expect_now("R1 reset state");

      // left-to-right line, right pin enables
      for (int k = 0; k < NGRP; k++) shift(4'((k * 7 + 3) & 15));
      expect_now("R6 handoff low, R7 not yet latched");
      shift(4'hF);
      expect_now("R6 extra nibble ignored before latch");
      latch();
      expect_now("R2 left fill after latch, R7 rearmed");
      ac_m = 1'b1;
      expect_now("R8 alternation high");
      blank_n = 1'b0;
      expect_now("R9 blanking");
      blank_n = 1'b1;
      ac_m = 1'b0;

      // disabled chip
      en_r_i = 1'b1;
      for (int k = 0; k < 5; k++) shift(4'((k * 5 + 9) & 15));
      expect_now("R5 disabled, no handoff");
      latch();
      expect_now("R5 data ignored while disabled");

      // right-to-left line, left pin enables, right pin input ignored
      dir_rl = 1'b1;
      en_l_i = 1'b0;
      for (int k = 0; k < NGRP - 1; k++) shift(4'((k * 11 + 6) & 15));
      expect_now("R4 swapped roles before full");
      shift(4'hA);
      expect_now("R4 swapped output pin goes low");
      latch();
      expect_now("R3 right fill");
      ac_m = 1'b1;
      expect_now("R8 alternation on right fill");
      ac_m = 1'b0;

      // partial line, other pin high must not matter
      dir_rl = 1'b0;
      en_r_i = 1'b0;
      en_l_i = 1'b1;
      for (int k = 0; k < 5; k++) shift(4'((k * 3 + 1) & 15));
      latch();
      expect_now("R4 unselected pin ignored, R7 partial latch");
      shift(4'h6);
      latch();
      expect_now("R7 counter cleared by latch");

      // reset in the middle of a line
      for (int k = 0; k < 3; k++) shift(4'hC);
      do_reset();
      expect_now("R1 reset mid line");

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule